// File: doc/BRIEF.md
# Dual-Event Classification Detector

This block follows the port voltage of a powered device from the first probe of the supply up to the point where application power is running. It decides whether the supply ran a two-event hardware classification, which a type 2 supply uses to grant higher power. It then drives the enable of an active-low, open-drain indicator. An application processor reads that indicator after boot to choose between taking full power and negotiating power over the link layer.

The port voltage arrives as an unsigned code in 0.1 V steps, at most one sample per clock, qualified by a valid strobe. A power-good input comes from the inrush/power-up controller. The block sorts each sample into one of four voltage windows: reset, detection, mark and classification. A window counts only after it has held for DWELL consecutive valid samples. A sequencer then walks through detection, first classification, mark and second classification. It sets the indicator only when power-good arrives after the full two-event sequence.

Top module: `dual_class_detect`

## Requirements
- R1: After reset, the indicator enable `flag_pull_en_o` is 0 (high impedance), `dbg_events_o` is 0 and `dbg_state_o` is 0. The state codes are: 0 idle, 1 detected, 2 first class, 3 mark, 4 second class, 5 powered.
- R2: A window counts only after DWELL (default 8) consecutive valid samples inside it. A shorter stay followed by a valid sample outside the window counts nothing. Samples with `smp_valid_i` low neither advance nor break a run, whatever their code.
- R3: In idle, a qualified detection window moves the block to state 1. The detection window is codes 27 to 101, excluding codes that fall in the reset window.
- R4: A qualified classification window (codes 145 to 205) counts one event. It does so in state 1 (moving to state 2) and in state 3 (moving to state 4), where the mark window (codes 69 to 101) must qualify between the two events. The event count never exceeds 2 and never steps by more than 1.
- R5: If power-good is high in state 4, the block moves to state 5 and asserts the indicator enable in the same cycle.
- R6: The indicator enable is never 1 unless power-good was high on the previous clock edge. It is never 1 during detection or classification.
- R7: If power-good arrives in state 1, with no classification seen, the block enters state 5 with the indicator off.
- R8: If power-good arrives after a single classification event (state 2 or 3), the block enters state 5 with the indicator off.
- R9: A qualified reset window (codes below 28), in any state other than idle or powered, returns the block to idle with the event count cleared. This voids a sequence that strays into the reset range between events.
- R10: If power-good falls in state 5, the indicator clears and the block returns to idle. Power-good returning without a new detection sequence leaves the indicator off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid_i | input | 1 | Port voltage sample strobe |
| smp_code_i | input | VW (10) | Port voltage in 0.1 V units |
| pwr_good_i | input | 1 | Application power-good from power-up controller |
| flag_pull_en_o | output | 1 | 1 = pull indicator low (two-event seen and power good), 0 = high impedance |
| dbg_state_o | output | 3 | Sequencer state code |
| dbg_events_o | output | 2 | Classification events counted |

## Verification
Properties check on every cycle that the indicator never rises without power-good on the prior edge, and that it only stands together with two counted events in the powered state. They also check that a qualified reset window before power-up empties the sequence, that the event count moves by one step or clears, and that losing power-good returns the block to idle. Whether a run of samples really qualifies, that invalid samples neither extend nor break a run, and the outcome of whole supply behaviours can only be shown by the bench's scenarios. Those behaviours are a skipped classification, a single event, a dip into the reset range, a short glitch and a power cycle.

// File: rtl/dcd_pkg.sv
// Shared types for the dual-event classification detector.
// Assumes four voltage windows; window indices are fixed here and used
// by the comparator, the dwell filters and the sequencer.
package dcd_pkg;

    localparam int NWIN   = 4;
    localparam int W_RST  = 0;
    localparam int W_DET  = 1;
    localparam int W_MARK = 2;
    localparam int W_CLS  = 3;

    localparam int EVW    = 2;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DET   = 3'd1,
        ST_CLS1  = 3'd2,
        ST_MARK1 = 3'd3,
        ST_CLS2  = 3'd4,
        ST_PWR   = 3'd5
    } dcd_state_e;

endpackage

// File: rtl/dcd_window_cmp.sv
// Sorts one port-voltage code into the four windows.
// Assumes thresholds are in the same 0.1 V units as the code. The reset
// window has priority over detection where the two overlap.
module dcd_window_cmp
    import dcd_pkg::*;
#(
    parameter int VW        = 10,
    parameter int RST_BELOW = 28,
    parameter int DET_LO    = 27,
    parameter int DET_HI    = 101,
    parameter int MARK_LO   = 69,
    parameter int MARK_HI   = 101,
    parameter int CLS_LO    = 145,
    parameter int CLS_HI    = 205
) (
    input  logic [VW-1:0]   code_i,
    output logic [NWIN-1:0] hit_o
);

    localparam logic [VW-1:0] RST_B = VW'(RST_BELOW);
    localparam logic [VW-1:0] DET_L = VW'(DET_LO);
    localparam logic [VW-1:0] DET_H = VW'(DET_HI);
    localparam logic [VW-1:0] MRK_L = VW'(MARK_LO);
    localparam logic [VW-1:0] MRK_H = VW'(MARK_HI);
    localparam logic [VW-1:0] CLS_L = VW'(CLS_LO);
    localparam logic [VW-1:0] CLS_H = VW'(CLS_HI);

    logic in_rst;

    // Compare the code against every window's bounds.
    always_comb begin
        in_rst         = (code_i < RST_B);
        hit_o          = '0;
        hit_o[W_RST]   = in_rst;
        hit_o[W_DET]   = !in_rst && (code_i >= DET_L) && (code_i <= DET_H);
        hit_o[W_MARK]  = (code_i >= MRK_L) && (code_i <= MRK_H);
        hit_o[W_CLS]   = (code_i >= CLS_L) && (code_i <= CLS_H);
    end

endmodule

// File: rtl/dcd_dwell_filter.sv
// Qualifies one window: the output goes high once DWELL consecutive valid
// samples have fallen inside the window, and stays high while they do.
// Assumes invalid samples carry no information and hold the run length.
module dcd_dwell_filter #(
    parameter int DWELL = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    input  logic in_win_i,
    output logic qual_o
);

    localparam int CW = $clog2(DWELL + 1);
    localparam logic [CW-1:0] LIM = CW'(DWELL);

    logic [CW-1:0] run_q;

    // Count consecutive in-window valid samples, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (valid_i) begin
            if (!in_win_i)       run_q <= '0;
            else if (run_q < LIM) run_q <= run_q + 1'b1;
        end
    end

    assign qual_o = (run_q >= LIM);

    // R2
    leave_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !in_win_i) |=> !qual_o)
        else $error("window qualification survived an out-of-window sample");

    // R2
    invalid_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(run_q))
        else $error("invalid sample changed the run length");

endmodule

// File: rtl/dcd_seq_fsm.sv
// Sequencer: detection, class event, mark, class event, then power.
// Assumes qualified window levels from the dwell filters and a power-good
// level from the power-up controller. The indicator is registered and
// set only on entry to, and while in, the powered state after two events.
module dcd_seq_fsm
    import dcd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NWIN-1:0] qual_i,
    input  logic            pg_i,
    output logic            flag_o,
    output dcd_state_e      st_o,
    output logic [EVW-1:0]  ev_o
);

    localparam logic [EVW-1:0] EV_TWO = EVW'(2);

    dcd_state_e     st_q, st_d;
    logic [EVW-1:0] ev_q, ev_d;
    logic           flag_q;
    logic           pre_pwr;

    assign pre_pwr = (st_q != ST_IDLE) && (st_q != ST_PWR);

    // Next state and event count; reset range first, then power-good.
    always_comb begin
        st_d = st_q;
        ev_d = ev_q;
        if (pre_pwr && qual_i[W_RST]) begin
            st_d = ST_IDLE;
            ev_d = '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    ev_d = '0;
                    if (qual_i[W_DET]) st_d = ST_DET;
                end
                ST_DET: begin
                    if (pg_i) st_d = ST_PWR;
                    else if (qual_i[W_CLS]) begin
                        st_d = ST_CLS1;
                        ev_d = ev_q + 1'b1;
                    end
                end
                ST_CLS1: begin
                    if (pg_i) st_d = ST_PWR;
                    else if (qual_i[W_MARK]) st_d = ST_MARK1;
                end
                ST_MARK1: begin
                    if (pg_i) st_d = ST_PWR;
                    else if (qual_i[W_CLS]) begin
                        st_d = ST_CLS2;
                        ev_d = ev_q + 1'b1;
                    end
                end
                ST_CLS2: begin
                    if (pg_i) st_d = ST_PWR;
                end
                ST_PWR: begin
                    if (!pg_i) begin
                        st_d = ST_IDLE;
                        ev_d = '0;
                    end
                end
                default: begin
                    st_d = ST_IDLE;
                    ev_d = '0;
                end
            endcase
        end
    end

    // State, count and indicator registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            ev_q   <= '0;
            flag_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            ev_q   <= ev_d;
            flag_q <= (st_d == ST_PWR) && (ev_d == EV_TWO);
        end
    end

    assign flag_o = flag_q;
    assign st_o   = st_q;
    assign ev_o   = ev_q;

    // R4
    event_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_q != $past(ev_q)) |-> ((ev_q == $past(ev_q) + 1'b1) || (ev_q == '0)))
        else $error("event count jumped");

    // R5
    flag_needs_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q |-> ((ev_q == EV_TWO) && (st_q == ST_PWR)))
        else $error("indicator set without two events in powered state");

    // R6
    flag_needs_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_i |=> !flag_q)
        else $error("indicator set without power good");

    // R9
    reset_voids_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_pwr && qual_i[W_RST]) |=> ((st_q == ST_IDLE) && (ev_q == '0)))
        else $error("reset range did not void the sequence");

    // R10
    pg_loss_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_PWR) && !pg_i) |=> ((st_q == ST_IDLE) && !flag_q))
        else $error("power good loss did not return to idle");

endmodule

// File: rtl/dual_class_detect.sv
// Top of the dual-event classification detector: window comparator,
// one dwell filter per window, and the sequencer.
// Assumes one port-voltage sample per clock at most, in 0.1 V codes.
module dual_class_detect
    import dcd_pkg::*;
#(
    parameter int VW        = 10,
    parameter int DWELL     = 8,
    parameter int RST_BELOW = 28,
    parameter int DET_LO    = 27,
    parameter int DET_HI    = 101,
    parameter int MARK_LO   = 69,
    parameter int MARK_HI   = 101,
    parameter int CLS_LO    = 145,
    parameter int CLS_HI    = 205
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid_i,
    input  logic [VW-1:0] smp_code_i,
    input  logic          pwr_good_i,
    output logic          flag_pull_en_o,
    output logic [2:0]    dbg_state_o,
    output logic [1:0]    dbg_events_o
);

    logic [NWIN-1:0] hit;
    logic [NWIN-1:0] qual;
    dcd_state_e      st;
    logic [EVW-1:0]  ev;

    dcd_window_cmp #(
        .VW(VW), .RST_BELOW(RST_BELOW), .DET_LO(DET_LO), .DET_HI(DET_HI),
        .MARK_LO(MARK_LO), .MARK_HI(MARK_HI), .CLS_LO(CLS_LO), .CLS_HI(CLS_HI)
    ) u_cmp (
        .code_i (smp_code_i),
        .hit_o  (hit)
    );

    // One qualification filter per window.
    for (genvar w = 0; w < NWIN; w++) begin : g_filt
        dcd_dwell_filter #(.DWELL(DWELL)) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .valid_i  (smp_valid_i),
            .in_win_i (hit[w]),
            .qual_o   (qual[w])
        );
    end

    dcd_seq_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .qual_i (qual),
        .pg_i   (pwr_good_i),
        .flag_o (flag_pull_en_o),
        .st_o   (st),
        .ev_o   (ev)
    );

    assign dbg_state_o  = st;
    assign dbg_events_o = ev;

endmodule

// File: tb/dual_class_detect_test.sv
// Scoreboard bench: driver tasks push expected items, a monitor pops
// and compares them against the outputs on falling edges.
module dual_class_detect_test;

    localparam int VW = 10;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid_i = 1'b0;
    logic [VW-1:0] smp_code_i = '0;
    logic          pwr_good_i = 1'b0;
    logic          flag_pull_en_o;
    logic [2:0]    dbg_state_o;
    logic [1:0]    dbg_events_o;

    always #5 clk = ~clk;

    dual_class_detect #(.VW(VW), .DWELL(DW)) uut (
        .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid_i),
        .smp_code_i(smp_code_i), .pwr_good_i(pwr_good_i),
        .flag_pull_en_o(flag_pull_en_o), .dbg_state_o(dbg_state_o),
        .dbg_events_o(dbg_events_o)
    );

    typedef struct {
        int    kind;   // 0 flag, 1 events, 2 state
        int    exp;
        string tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Monitor: pop one expected item per falling edge and compare.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            int act;
            it = q.pop_front();
            case (it.kind)
                0:       act = int'(flag_pull_en_o);
                1:       act = int'(dbg_events_o);
                default: act = int'(dbg_state_o);
            endcase
            checks++;
            if (act != it.exp) begin
                fails++;
                $display("FAIL %s kind=%0d: actual %0d expected %0d",
                         it.tag, it.kind, act, it.exp);
            end
        end
    end

    task automatic expect_val(input int kind, input int exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic feed(input int code, input int n);
        for (int i = 0; i < n; i++) begin
            smp_valid_i = 1'b1;
            smp_code_i  = VW'(code);
            @(posedge clk); #1;
        end
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            smp_valid_i = 1'b0;
            smp_code_i  = '0;
            @(posedge clk); #1;
        end
    endtask

    task automatic settle();
        smp_valid_i = 1'b0;
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic power(input logic v);
        pwr_good_i = v;
        settle();
    endtask

    // Bring the port back to a clean idle with power off.
    task automatic to_idle();
        pwr_good_i = 1'b0;
        feed(0, DW + 2);
        settle();
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        expect_val(0, 0, "R1");
        expect_val(1, 0, "R1");
        expect_val(2, 0, "R1");
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R3 detection
        feed(50, DW + 2);
        settle();
        expect_val(2, 1, "R3");

        // R2 short class stay does not count
        feed(170, DW - 1);
        feed(120, 3);
        settle();
        expect_val(1, 0, "R2");
        expect_val(2, 1, "R2");

        // R2 invalid samples (code 0) neither break nor count
        feed(170, 4);
        gap(5);
        feed(170, 4);
        settle();
        expect_val(1, 1, "R2");
        expect_val(2, 2, "R4");

        // R4 mark then second class event
        feed(80, DW + 2);
        settle();
        expect_val(2, 3, "R4");
        feed(180, DW + 2);
        settle();
        expect_val(1, 2, "R4");
        expect_val(2, 4, "R4");
        // R6 no indicator before power good
        expect_val(0, 0, "R6");

        // R5 power good after two events
        feed(480, DW + 2);
        power(1'b1);
        expect_val(0, 1, "R5");
        expect_val(2, 5, "R5");

        // R10 power loss clears, return without new sequence stays off
        power(1'b0);
        expect_val(0, 0, "R10");
        expect_val(2, 0, "R10");
        power(1'b1);
        expect_val(0, 0, "R10");

        // R7 classification skipped
        to_idle();
        feed(50, DW + 2);
        feed(480, DW + 2);
        power(1'b1);
        expect_val(0, 0, "R7");
        expect_val(2, 5, "R7");

        // R8 single event
        to_idle();
        feed(50, DW + 2);
        feed(170, DW + 2);
        feed(80, DW + 2);
        feed(480, DW + 2);
        power(1'b1);
        expect_val(0, 0, "R8");
        expect_val(1, 1, "R8");

        // R9 mark voltage strays into reset range
        to_idle();
        feed(50, DW + 2);
        feed(170, DW + 2);
        feed(80, DW + 2);
        feed(20, DW + 2);
        settle();
        expect_val(2, 0, "R9");
        expect_val(1, 0, "R9");
        feed(170, DW + 2);
        feed(480, DW + 2);
        power(1'b1);
        expect_val(0, 0, "R9");

        // R2 a brief dip below reset threshold is rejected
        to_idle();
        feed(50, DW + 2);
        feed(170, DW + 2);
        feed(80, DW + 2);
        feed(20, 3);
        feed(80, DW + 2);
        settle();
        expect_val(2, 3, "R2");
        feed(180, DW + 2);
        feed(480, DW + 2);
        power(1'b1);
        expect_val(0, 1, "R5");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule